// File: doc/BRIEF.md
# NAND Completion Wait Sequencer

After a command has gone out to a NAND flash device, this block waits for the device to finish. A single start pulse selects one of three wait kinds: a plain command wait, a wait after a device reset, or a program/erase wait. It then picks one of three ways to detect completion. It can watch the ready/busy pin. It can repeatedly fetch the device status byte through a small request/response port and test the ready bit (bit 6, value 0x40). Or, when neither method is available, it simply lets a programmable chip delay run out. Every wait that looks at the pin, and every program/erase wait, first spends a fixed write-to-busy settle time, so the device has time to pull its busy line low before anything is sampled.

Time is kept by a microsecond counter derived from the clock-frequency parameter. Polling ends either when the device reports ready or when the limit for that wait kind expires. Reset waits that poll the status byte use their own, shorter limit. When the wait finishes, a one-cycle done pulse appears together with three held results: the final status byte (for waits that read one), a timeout flag, and an error flag that is set when the returned status lacks the ready bit. Program/erase waits always finish with one extra status read, and that read supplies the reported byte.

Top module: `nand_rdy_waiter`

## Requirements
- R1: A start_i pulse while idle launches a wait and samples kind_i, pin_en_i and dly_us_i. busy_o is high from the next cycle until the cycle after done_o. A start_i pulse while busy_o is high has no effect on the running wait.
- R2: For kind_i 00 or 11 (command wait) with pin_en_i low, the block waits the chip delay of D microseconds. done_o rises on the D*(CLK_HZ/10^6)+1-th rising edge after the edge that samples start_i.
- R3: A dly_us_i of 0 selects DEF_DLY_US microseconds (20 by default) as the chip delay.
- R4: When pin_en_i is high, or kind_i is 10 (program/erase), a settle wait of ceil(PRE_NS*CLK_HZ/10^9) cycles comes first and is never cut short. With the pin already ready, a command or reset wait raises done_o PRE_CYC+1 edges after the start edge, and a program/erase wait raises it PRE_CYC+4 edges after.
- R5: Pin polling (ready = rb_i high, passed through SYNC_STAGES flops) ends with tmo_o=1 when the pin is still low NORM_TMO_US microseconds after polling began. This limit applies to command and reset waits alike. A pin that rises earlier ends the wait with tmo_o=0.
- R6: For kind_i 01 (reset) with pin_en_i low, the block runs the chip delay, then gives one st_cmd_o pulse, then reads status bytes until one has bit 6 (0x40) set. status_o is that byte.
- R7: Status polling after a reset gives up RST_TMO_US microseconds after the status command. It then reports tmo_o=1, and status_o holds the last byte read.
- R8: A program/erase wait gives exactly one st_cmd_o pulse after the settle wait. It then polls the pin (pin_en_i high) or the status byte, and finishes with exactly one more status read whose byte becomes status_o. Command waits never pulse st_cmd_o.
- R9: bad_o is 1 exactly when the byte reported in status_o lacks bit 6. Waits that read no status report status_o=0 and bad_o=0.
- R10: A program/erase wait that times out still performs its final status read and reports that byte, with tmo_o=1.
- R11: done_o lasts one cycle. status_o, tmo_o and bad_o hold their values from done_o until the next accepted start, which clears them.
- R12: Each status read is a one-cycle st_rd_o pulse. The block waits for st_vld_i to take st_byte_i and issues no new request before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse |
| kind_i | input | 2 | Wait kind: 00/11 command, 01 reset, 10 program/erase |
| pin_en_i | input | 1 | Ready/busy pin is available for polling |
| dly_us_i | input | DLY_W | Chip delay in microseconds, 0 selects default |
| rb_i | input | 1 | Ready/busy pin, high = ready |
| st_cmd_o | output | 1 | Pulse: issue status command |
| st_rd_o | output | 1 | Pulse: fetch one status byte |
| st_vld_i | input | 1 | Status byte response valid |
| st_byte_i | input | 8 | Status byte response |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Final status byte |
| tmo_o | output | 1 | Wait ended by timeout |
| bad_o | output | 1 | Reported status lacks ready bit |

## Verification
The chip delay is swept over several small values for both command encodings, plus the zero value. This separates the microsecond scaling from the default substitution. Pin waits are run with the pin ready before start, never ready, and rising mid-poll. Exact latencies distinguish the settle time, the limit used, and the synchronizer depth. Status-polled reset and program waits are run with the ready bit appearing after zero to three busy reads, and with a device that never gets ready. The read and command pulse counts then show the extra final read, the separate reset limit and the error flag.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

   typedef enum logic [1:0] {
      K_CMD  = 2'd0,
      K_RST  = 2'd1,
      K_PROG = 2'd2,
      K_CMD2 = 2'd3
   } wait_kind_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PRE,
      S_DLY,
      S_SCMD,
      S_PIN,
      S_RREQ,
      S_RWAIT,
      S_FREQ,
      S_FWAIT,
      S_DONE
   } wait_state_e;

endpackage

// File: rtl/nrw_timer.sv
module nrw_timer #(
   parameter int DIV   = 100,
   parameter int DIV_W = 7,
   parameter int CYC_W = 5,
   parameter int US_W  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CYC_W-1:0] cyc_o,
   output logic [US_W-1:0]  us_o
);

   logic tick;

   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        div_q <= '0;
            else if (clr)                      div_q <= '0;
            else if (div_q == DIV_W'(DIV - 1)) div_q <= '0;
            else                               div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   us_o <= '0;
      else if (clr)                 us_o <= '0;
      else if (tick && us_o != '1)  us_o <= us_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc_o <= '0;
      else if (clr)         cyc_o <= '0;
      else if (cyc_o != '1) cyc_o <= cyc_o + 1'b1;
   end

endmodule

// File: rtl/nrw_sync.sv
module nrw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], d};
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nrw_seq.sv
module nrw_seq
   import nrw_pkg::*;
#(
   parameter int PRE_CYC  = 10,
   parameter int CYC_W    = 5,
   parameter int US_W     = 20,
   parameter int DLY_W    = 16,
   parameter int NORM_TMO = 400000,
   parameter int RST_TMO  = 250000,
   parameter int DEF_DLY  = 20,
   parameter int RDY_BIT  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       kind_i,
   input  logic             pin_en_i,
   input  logic [DLY_W-1:0] dly_us_i,
   input  logic             rdy_i,
   input  logic             st_vld_i,
   input  logic [7:0]       st_byte_i,
   input  logic [CYC_W-1:0] cyc_i,
   input  logic [US_W-1:0]  us_i,
   output logic             tmr_clr_o,
   output logic             st_cmd_o,
   output logic             st_rd_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [7:0]       status_o,
   output logic             tmo_o,
   output logic             bad_o
);

   localparam logic [US_W-1:0]  NORM_LIM = US_W'(NORM_TMO);
   localparam logic [US_W-1:0]  RST_LIM  = US_W'(RST_TMO);
   localparam logic [US_W-1:0]  DEF_LIM  = US_W'(DEF_DLY);
   localparam logic [CYC_W-1:0] PRE_LAST = CYC_W'(PRE_CYC - 1);

   wait_state_e      st_q, nxt;
   wait_kind_e       kind_q;
   logic             pin_q;
   logic [US_W-1:0]  dly_q;
   logic             set_tmo, cap;
   logic             is_prog;
   logic [US_W-1:0]  poll_lim;

   assign is_prog  = (kind_q == K_PROG);
   assign poll_lim = (kind_q == K_RST) ? RST_LIM : NORM_LIM;

   always_comb begin
      nxt     = st_q;
      set_tmo = 1'b0;
      cap     = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (start_i)
               nxt = (pin_en_i || wait_kind_e'(kind_i) == K_PROG) ? S_PRE : S_DLY;
         end
         S_PRE: begin
            if (cyc_i >= PRE_LAST) nxt = is_prog ? S_SCMD : S_PIN;
         end
         S_DLY: begin
            if (us_i >= dly_q) nxt = (kind_q == K_RST) ? S_SCMD : S_DONE;
         end
         S_SCMD: nxt = pin_q ? S_PIN : S_RREQ;
         S_PIN: begin
            if (rdy_i) begin
               nxt = is_prog ? S_FREQ : S_DONE;
            end else if (us_i >= NORM_LIM) begin
               set_tmo = 1'b1;
               nxt     = is_prog ? S_FREQ : S_DONE;
            end
         end
         S_RREQ: nxt = S_RWAIT;
         S_RWAIT: begin
            if (st_vld_i) begin
               if (st_byte_i[RDY_BIT] || us_i >= poll_lim) begin
                  set_tmo = !st_byte_i[RDY_BIT];
                  if (is_prog) begin
                     nxt = S_FREQ;
                  end else begin
                     cap = 1'b1;
                     nxt = S_DONE;
                  end
               end else begin
                  nxt = S_RREQ;
               end
            end
         end
         S_FREQ: nxt = S_FWAIT;
         S_FWAIT: begin
            if (st_vld_i) begin
               cap = 1'b1;
               nxt = S_DONE;
            end
         end
         S_DONE:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   assign tmr_clr_o = (nxt != st_q) &&
                      (nxt == S_PRE || nxt == S_DLY || nxt == S_PIN || nxt == S_SCMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         kind_q   <= K_CMD;
         pin_q    <= 1'b0;
         dly_q    <= '0;
         status_o <= '0;
         tmo_o    <= 1'b0;
         bad_o    <= 1'b0;
      end else begin
         st_q <= nxt;
         if (st_q == S_IDLE && start_i) begin
            kind_q   <= wait_kind_e'(kind_i);
            pin_q    <= pin_en_i;
            dly_q    <= (dly_us_i == '0) ? DEF_LIM : US_W'(dly_us_i);
            status_o <= '0;
            tmo_o    <= 1'b0;
            bad_o    <= 1'b0;
         end else begin
            if (set_tmo) tmo_o <= 1'b1;
            if (cap) begin
               status_o <= st_byte_i;
               bad_o    <= !st_byte_i[RDY_BIT];
            end
         end
      end
   end

   assign st_cmd_o = (st_q == S_SCMD);
   assign st_rd_o  = (st_q == S_RREQ) || (st_q == S_FREQ);
   assign busy_o   = (st_q != S_IDLE);
   assign done_o   = (st_q == S_DONE);

endmodule

// File: rtl/nand_rdy_waiter.sv
module nand_rdy_waiter #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int PRE_NS      = 100,
   parameter int NORM_TMO_US = 400_000,
   parameter int RST_TMO_US  = 250_000,
   parameter int DEF_DLY_US  = 20,
   parameter int DLY_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_BIT     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       kind_i,
   input  logic             pin_en_i,
   input  logic [DLY_W-1:0] dly_us_i,
   input  logic             rb_i,
   output logic             st_cmd_o,
   output logic             st_rd_o,
   input  logic             st_vld_i,
   input  logic [7:0]       st_byte_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [7:0]       status_o,
   output logic             tmo_o,
   output logic             bad_o
);

   localparam int    DIV       = CLK_HZ / 1_000_000;
   localparam int    DIV_W     = (DIV > 1) ? $clog2(DIV) : 1;
   localparam longint PRE_RAW  = (longint'(PRE_NS) * longint'(CLK_HZ) + 64'd999_999_999)
                                 / 64'd1_000_000_000;
   localparam int    PRE_CYC   = (PRE_RAW < 1) ? 1 : int'(PRE_RAW);
   localparam int    CYC_W     = $clog2(PRE_CYC + 1) + 1;
   localparam longint DLY_MAX  = (longint'(1) << DLY_W) - 1;
   localparam longint MAX_A    = (NORM_TMO_US > RST_TMO_US) ? NORM_TMO_US : RST_TMO_US;
   localparam longint MAX_B    = (MAX_A > DEF_DLY_US) ? MAX_A : DEF_DLY_US;
   localparam longint MAX_US   = (MAX_B > DLY_MAX) ? MAX_B : DLY_MAX;
   localparam int    US_W      = $clog2(MAX_US + 2);

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_chk_clk
         $error("CLK_HZ must be a whole number of MHz");
      end
      if (NORM_TMO_US < 1 || RST_TMO_US < 1 || DEF_DLY_US < 1) begin : g_chk_lim
         $error("time limits must be at least one microsecond");
      end
      if (RDY_BIT < 0 || RDY_BIT > 7) begin : g_chk_bit
         $error("RDY_BIT must index the status byte");
      end
      if (SYNC_STAGES < 0 || DLY_W < 1 || DLY_W > 24) begin : g_chk_misc
         $error("SYNC_STAGES or DLY_W out of range");
      end
   endgenerate

   logic             rdy_s;
   logic             tmr_clr;
   logic [CYC_W-1:0] cyc;
   logic [US_W-1:0]  us;

   nrw_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rb_i),
      .q     (rdy_s)
   );

   nrw_timer #(
      .DIV   (DIV),
      .DIV_W (DIV_W),
      .CYC_W (CYC_W),
      .US_W  (US_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cyc_o (cyc),
      .us_o  (us)
   );

   nrw_seq #(
      .PRE_CYC  (PRE_CYC),
      .CYC_W    (CYC_W),
      .US_W     (US_W),
      .DLY_W    (DLY_W),
      .NORM_TMO (NORM_TMO_US),
      .RST_TMO  (RST_TMO_US),
      .DEF_DLY  (DEF_DLY_US),
      .RDY_BIT  (RDY_BIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .kind_i    (kind_i),
      .pin_en_i  (pin_en_i),
      .dly_us_i  (dly_us_i),
      .rdy_i     (rdy_s),
      .st_vld_i  (st_vld_i),
      .st_byte_i (st_byte_i),
      .cyc_i     (cyc),
      .us_i      (us),
      .tmr_clr_o (tmr_clr),
      .st_cmd_o  (st_cmd_o),
      .st_rd_o   (st_rd_o),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .status_o  (status_o),
      .tmo_o     (tmo_o),
      .bad_o     (bad_o)
   );

endmodule

// File: rtl/nrw_chk.sv
module nrw_chk #(
   parameter int RDY_BIT = 6
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       st_cmd_o,
   input logic       st_rd_o,
   input logic       busy_o,
   input logic       done_o,
   input logic [7:0] status_o,
   input logic       bad_o
);

   assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o) && !$past(start_i)) |-> $stable(status_o));

   assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_cmd_o |=> !st_cmd_o);

   assert_req_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_cmd_o && st_rd_o));

   assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd_o |=> !st_rd_o);

   assert_rd_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd_o |-> busy_o);

   assert_bad_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && bad_o) |-> !status_o[RDY_BIT]);

endmodule

bind nand_rdy_waiter nrw_chk #(
   .RDY_BIT (RDY_BIT)
) u_nrw_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .st_cmd_o (st_cmd_o),
   .st_rd_o  (st_rd_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .status_o (status_o),
   .bad_o    (bad_o)
);

// File: tb/nand_rdy_waiter_bench.sv
`timescale 1ns/1ps
module nand_rdy_waiter_bench;

   localparam int CLK_HZ  = 100_000_000;
   localparam int DIV     = CLK_HZ / 1_000_000;
   localparam int PRE     = 10;
   localparam int NORM    = 20;
   localparam int RSTL    = 12;
   localparam int DEFD    = 20;
   localparam int SYNC    = 2;
   localparam logic [7:0] READY_B = 8'hC1;
   localparam logic [7:0] BUSY_B  = 8'h82;
   localparam int NEVER   = 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] kind = 2'd0;
   logic       pin = 1'b0;
   logic [7:0] dly = 8'd0;
   logic       rb = 1'b0;
   logic       st_cmd, st_rd;
   logic       st_vld = 1'b0;
   logic [7:0] st_byte = 8'h00;
   logic       busy, done, tmo, bad;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit fin = 1'b0;
   int rd_cnt = 0, cmd_cnt = 0;
   int rd_base = 0, cmd_base = 0, rdy_after = 0;
   int lat, reads, cmds;
   logic [7:0] r_stat;
   logic r_tmo, r_bad;

   always #5 clk = ~clk;

   nand_rdy_waiter #(
      .CLK_HZ      (CLK_HZ),
      .PRE_NS      (100),
      .NORM_TMO_US (NORM),
      .RST_TMO_US  (RSTL),
      .DEF_DLY_US  (DEFD),
      .DLY_W       (8),
      .SYNC_STAGES (SYNC),
      .RDY_BIT     (6)
   ) u_nand_rdy_waiter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .kind_i    (kind),
      .pin_en_i  (pin),
      .dly_us_i  (dly),
      .rb_i      (rb),
      .st_cmd_o  (st_cmd),
      .st_rd_o   (st_rd),
      .st_vld_i  (st_vld),
      .st_byte_i (st_byte),
      .busy_o    (busy),
      .done_o    (done),
      .status_o  (status),
      .tmo_o     (tmo),
      .bad_o     (bad)
   );

   // device model: answers each read one cycle later, ready after rdy_after busy reads
   always @(posedge clk) begin
      st_vld <= st_rd;
      if (st_rd) begin
         st_byte <= ((rd_cnt - rd_base) >= rdy_after) ? READY_B : BUSY_B;
         rd_cnt  <= rd_cnt + 1;
      end
      if (st_cmd) cmd_cnt <= cmd_cnt + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] k, input logic p, input int d,
                      input int rdy_n, input int raise_at, input int ign_at);
      @(negedge clk);
      kind = k; pin = p; dly = 8'(d); rdy_after = rdy_n;
      rd_base = rd_cnt; cmd_base = cmd_cnt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 6000) begin
         if (lat == raise_at) rb = 1'b1;
         start = (lat == ign_at);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      r_stat = status; r_tmo = tmo; r_bad = bad;
      reads = rd_cnt - rd_base; cmds = cmd_cnt - cmd_base;
      @(negedge clk);
      chk("R11 done one cycle", int'(done), 0);
      chk("R11 status held", int'(status), int'(r_stat));
      chk("R1 idle after done", int'(busy), 0);
   endtask

   initial begin
      repeat (150_000) @(posedge clk);
      if (!fin) begin
         errors++;
         $display("FAIL R1 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy", int'(busy), 0);
      chk("R11 reset done", int'(done), 0);
      chk("R11 reset tmo", int'(tmo), 0);
      chk("R9 reset status", int'(status), 0);
      chk("R8 reset st_cmd", int'(st_cmd), 0);
      chk("R12 reset st_rd", int'(st_rd), 0);

      // R2: chip-delay sweep on both command encodings
      for (int k = 0; k < 4; k += 3) begin
         for (int d = 1; d <= 4; d++) begin
            run(2'(k), 1'b0, d, 0, -1, -1);
            chk("R2 delay latency", lat, d * DIV + 2);
            chk("R8 no status cmd", cmds, 0);
            chk("R9 no status", int'(r_stat), 0);
            chk("R9 no bad", int'(r_bad), 0);
         end
      end

      // R3: zero selects default
      run(2'd0, 1'b0, 0, 0, -1, -1);
      chk("R3 default delay", lat, DEFD * DIV + 2);

      // R1: start while busy ignored
      run(2'd0, 1'b0, 3, 0, -1, 40);
      chk("R1 ignored start latency", lat, 3 * DIV + 2);
      repeat (3) @(negedge clk);
      chk("R1 no relaunch", int'(busy), 0);

      // R4: pin already ready, settle time not skipped
      rb = 1'b1;
      repeat (5) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         run(2'(k), 1'b1, 5, 0, -1, -1);
         chk("R4 settle then ready", lat, PRE + 2);
         chk("R4 no tmo", int'(r_tmo), 0);
         chk("R9 pin no status", int'(r_stat), 0);
      end

      // R4/R8/R9: program wait, pin ready, final read
      run(2'd2, 1'b1, 5, 0, -1, -1);
      chk("R4 program latency", lat, PRE + 5);
      chk("R8 one status cmd", cmds, 1);
      chk("R8 one final read", reads, 1);
      chk("R8 final status", int'(r_stat), int'(READY_B));
      chk("R9 ready not bad", int'(r_bad), 0);
      run(2'd2, 1'b1, 5, NEVER, -1, -1);
      chk("R9 final busy byte", int'(r_stat), int'(BUSY_B));
      chk("R9 bad flagged", int'(r_bad), 1);
      chk("R9 no tmo", int'(r_tmo), 0);

      // R5: pin timeout, normal limit for command and reset
      rb = 1'b0;
      repeat (5) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         run(2'(k), 1'b1, 5, 0, -1, -1);
         chk("R5 pin timeout latency", lat, PRE + NORM * DIV + 2);
         chk("R5 tmo set", int'(r_tmo), 1);
      end
      run(2'd0, 1'b0, 1, 0, -1, -1);
      chk("R11 start clears tmo", int'(r_tmo), 0);

      // R5: pin rises mid-poll
      run(2'd0, 1'b1, 5, 0, 300, -1);
      chk("R5 early ready latency", lat, 300 + SYNC + 1);
      chk("R5 early ready no tmo", int'(r_tmo), 0);
      rb = 1'b0;
      repeat (5) @(negedge clk);

      // R6/R12: reset with status polling
      for (int r = 0; r < 4; r++) begin
         run(2'd1, 1'b0, 1, r, -1, -1);
         chk("R6 status cmd", cmds, 1);
         chk("R12 poll reads", reads, r + 1);
         chk("R6 ready byte", int'(r_stat), int'(READY_B));
         chk("R6 no tmo", int'(r_tmo), 0);
      end

      // R7: reset polling limit
      run(2'd1, 1'b0, 1, NEVER, -1, -1);
      chk("R7 tmo", int'(r_tmo), 1);
      chk("R7 last byte", int'(r_stat), int'(BUSY_B));
      chk("R9 reset bad", int'(r_bad), 1);
      chk("R7 not before limit", int'(lat >= DIV + RSTL * DIV), 1);
      chk("R7 reset limit used", int'(lat <= DIV + RSTL * DIV + 12), 1);

      // R8/R12: program wait with status polling
      for (int r = 0; r < 4; r++) begin
         run(2'd2, 1'b0, 5, r, -1, -1);
         chk("R8 status cmd", cmds, 1);
         chk("R12 poll plus final reads", reads, r + 2);
         chk("R8 final byte", int'(r_stat), int'(READY_B));
      end

      // R10: program timeouts
      run(2'd2, 1'b1, 5, 0, -1, -1);
      chk("R10 pin tmo", int'(r_tmo), 1);
      chk("R10 final read made", reads, 1);
      chk("R10 status reported", int'(r_stat), int'(READY_B));
      chk("R10 not bad", int'(r_bad), 0);
      run(2'd2, 1'b0, 5, NEVER, -1, -1);
      chk("R10 poll tmo", int'(r_tmo), 1);
      chk("R10 reads made", int'(reads >= 2), 1);
      chk("R10 busy byte", int'(r_stat), int'(BUSY_B));
      chk("R10 bad", int'(r_bad), 1);

      fin = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule